// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two words from a page table tree in memory. A requester offers the linear address with the byte address of the top-level directory. The walker first reads the directory entry and then, if that entry is marked present, reads the entry in the second-level table that it names. It then reports either the composed physical address or a page fault.

The memory side is a single read port. The request address has a valid/ready handshake, and the response has its own valid with no backpressure. The walker keeps one read in flight and waits as long as the memory needs. The result appears on a one-cycle done pulse. A new request is taken only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held, and at the first edge after it is released, req_ready_o is 1, mem_req_valid_o is 0 and done_o is 0.
- R2: The linear address is split into three fields: bits 11:0 are the page offset, bits 21:12 are the table index and bits 31:22 are the directory index.
- R3: The first read of every walk goes to the sampled directory base plus 4 times the directory index.
- R4: The second read goes to (directory entry bits 31:12, shifted left by 12) plus 4 times the table index.
- R5: Bit 0 of an entry is its present flag. When the directory entry has bit 0 clear, the walk ends with fault_o = 1 and makes no second read.
- R6: When the table entry has bit 0 clear, the walk ends with fault_o = 1, whatever its frame bits hold.
- R7: On success phys_addr_o is {table entry bits 31:12, linear bits 11:0}. Bits 11:1 of both entries have no effect on the result.
- R8: done_o stays high for exactly one cycle per walk. fault_o and phys_addr_o are 0 whenever done_o is low, and phys_addr_o is 0 whenever fault_o is 1.
- R9: A request is accepted only on an edge where req_ready_o and req_valid_i are both 1. The address and base are sampled at that edge, and later changes to them have no effect on the walk.
- R10: mem_req_valid_o stays high with a stable address until mem_req_ready_i is seen. Any number of cycles may pass before the response. A response valid outside a wait for data is ignored.
- R11: req_ready_o returns in the cycle after done_o, so a held request starts the next walk without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Linear address to translate |
| req_base_i | input | 32 | Byte address of the top-level directory |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry word returned by memory |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Page fault, valid with done_o |
| phys_addr_o | output | 32 | Physical address, valid with done_o |

## Verification
A walker in the wrong state shows it at the ports within one cycle. It either drops or raises req_ready_o at the wrong time, or issues mem_req_valid_o with an address that does not match the expected directory or table entry. The bench therefore compares every port against a behavioural model on every clock. A wrongly latched base, index or frame shows in mem_req_addr_o before the read completes, and a wrong present decision shows as an extra or missing second read and a wrong fault on the done cycle. Stalled ready, varied response latency and spurious response strobes outside the wait states expose handshake slips within a few cycles of the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DIR_IDX_W  = 10;
  localparam int unsigned TBL_IDX_W  = 10;
  localparam int unsigned OFF_W      = 12;
  localparam int unsigned ENTRY_LOG2 = 2;
  localparam int unsigned FRAME_W    = ADDR_W - OFF_W;
  localparam int unsigned PRESENT_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int unsigned ADDR_W      = ptw_pkg::ADDR_W,
  parameter int unsigned OFF_W       = ptw_pkg::OFF_W,
  parameter int unsigned PRESENT_BIT = ptw_pkg::PRESENT_BIT,
  localparam int unsigned FRAME_W    = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  entry_i,
  output logic               present_o,
  output logic [FRAME_W-1:0] frame_o
);
  // bits between the flag and the frame are don't-care
  assign present_o = entry_i[PRESENT_BIT];
  assign frame_o   = entry_i[ADDR_W-1:OFF_W];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned ADDR_W     = ptw_pkg::ADDR_W,
  parameter int unsigned DIR_IDX_W  = ptw_pkg::DIR_IDX_W,
  parameter int unsigned TBL_IDX_W  = ptw_pkg::TBL_IDX_W,
  parameter int unsigned OFF_W      = ptw_pkg::OFF_W,
  parameter int unsigned ENTRY_LOG2 = ptw_pkg::ENTRY_LOG2,
  localparam int unsigned FRAME_W   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  vaddr_i,
  input  logic [ADDR_W-1:0]  dir_base_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic               sel_tbl_i,
  input  logic [FRAME_W-1:0] page_frame_i,
  output logic [ADDR_W-1:0]  entry_addr_o,
  output logic [ADDR_W-1:0]  phys_o
);
  localparam int unsigned TBL_LSB = OFF_W;
  localparam int unsigned DIR_LSB = OFF_W + TBL_IDX_W;
  localparam int unsigned DIR_PAD = ADDR_W - DIR_IDX_W - ENTRY_LOG2;
  localparam int unsigned TBL_PAD = ADDR_W - TBL_IDX_W - ENTRY_LOG2;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     offset;
  logic [ADDR_W-1:0]    dir_ofs, tbl_ofs, tbl_base;

  assign dir_idx = vaddr_i[DIR_LSB +: DIR_IDX_W];
  assign tbl_idx = vaddr_i[TBL_LSB +: TBL_IDX_W];
  assign offset  = vaddr_i[OFF_W-1:0];

  assign dir_ofs  = {{DIR_PAD{1'b0}}, dir_idx, {ENTRY_LOG2{1'b0}}};
  assign tbl_ofs  = {{TBL_PAD{1'b0}}, tbl_idx, {ENTRY_LOG2{1'b0}}};
  assign tbl_base = {tbl_frame_i, {OFF_W{1'b0}}};

  assign entry_addr_o = sel_tbl_i ? (tbl_base + tbl_ofs) : (dir_base_i + dir_ofs);
  assign phys_o       = {page_frame_i, offset};
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_req_ready_i,
  input  logic        mem_rsp_valid_i,
  input  logic        present_i,
  output walk_state_e state_o,
  output logic        load_req_o,
  output logic        load_tbl_o,
  output logic        load_res_o,
  output logic        res_fault_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    load_req_o  = 1'b0;
    load_tbl_o  = 1'b0;
    load_res_o  = 1'b0;
    res_fault_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        load_req_o = 1'b1;
        state_d    = ST_RD_DIR;
      end
      ST_RD_DIR: if (mem_req_ready_i) state_d = ST_WT_DIR;
      ST_WT_DIR: if (mem_rsp_valid_i) begin
        if (present_i) begin
          load_tbl_o = 1'b1;
          state_d    = ST_RD_TBL;
        end else begin
          load_res_o  = 1'b1;
          res_fault_o = 1'b1;
          state_d     = ST_DONE;
        end
      end
      ST_RD_TBL: if (mem_req_ready_i) state_d = ST_WT_TBL;
      ST_WT_TBL: if (mem_rsp_valid_i) begin
        load_res_o  = 1'b1;
        res_fault_o = ~present_i;
        state_d     = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: a missing directory entry goes straight to the result, never to a table read
  a_r5_dir_fault_skips_tbl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WT_DIR && mem_rsp_valid_i && !present_i) |=> (state_q == ST_DONE));

  // R11: the result cycle is always followed by idle
  a_r11_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R10: response strobes outside a wait state leave the state alone
  a_r10_stray_rsp_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && (state_q == ST_RD_DIR || state_q == ST_RD_TBL) && !mem_req_ready_i)
      |=> $stable(state_q));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_vaddr_i,
  input  logic [31:0] req_base_i,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  output logic        done_o,
  output logic        fault_o,
  output logic [31:0] phys_addr_o
);
  walk_state_e        state;
  logic               load_req, load_tbl, load_res, res_fault;
  logic               present;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  vaddr_q, base_q, entry_addr, phys_new;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic               fault_q;
  logic [ADDR_W-1:0]  phys_q;

  ptw_fsm i_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .present_i       (present),
    .state_o         (state),
    .load_req_o      (load_req),
    .load_tbl_o      (load_tbl),
    .load_res_o      (load_res),
    .res_fault_o     (res_fault)
  );

  ptw_entry_decode i_decode (
    .entry_i   (mem_rsp_data_i),
    .present_o (present),
    .frame_o   (frame)
  );

  ptw_addr_gen i_addr (
    .vaddr_i      (vaddr_q),
    .dir_base_i   (base_q),
    .tbl_frame_i  (tbl_frame_q),
    .sel_tbl_i    (state == ST_RD_TBL),
    .page_frame_i (frame),
    .entry_addr_o (entry_addr),
    .phys_o       (phys_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q     <= '0;
      base_q      <= '0;
      tbl_frame_q <= '0;
      fault_q     <= 1'b0;
      phys_q      <= '0;
    end else begin
      if (load_req) begin
        vaddr_q <= req_vaddr_i;
        base_q  <= req_base_i;
      end
      if (load_tbl) tbl_frame_q <= frame;
      if (load_res) begin
        fault_q <= res_fault;
        phys_q  <= res_fault ? '0 : phys_new;
      end
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign mem_req_valid_o = (state == ST_RD_DIR) || (state == ST_RD_TBL);
  assign mem_req_addr_o  = entry_addr;
  assign done_o          = (state == ST_DONE);
  assign fault_o         = done_o & fault_q;
  assign phys_addr_o     = done_o ? phys_q : '0;

  // R10: a pending read holds its address until taken
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R8: single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: no address reported with a fault
  a_r8_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (phys_addr_o == '0));

  // R9: request side and memory side never active together
  a_r9_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_valid_o && !done_o));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] req_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        done_o, fault_o;
  logic [31:0] phys_addr_o;

  always #2.5 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_base_i(req_base_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .done_o(done_o), .fault_o(fault_o), .phys_addr_o(phys_addr_o)
  );

  int errors = 0, checks = 0, cyc = 0, reads = 0;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // inputs as seen at the last rising edge
  logic        c_rst, c_req_valid, c_mem_ready, c_rsp_valid, c_mem_valid;
  logic [31:0] c_vaddr, c_base, c_rsp_data, c_mem_addr;
  always @(posedge clk) begin
    c_rst = rst_ni; c_req_valid = req_valid_i; c_vaddr = req_vaddr_i; c_base = req_base_i;
    c_mem_ready = mem_req_ready_i; c_rsp_valid = mem_rsp_valid_i; c_rsp_data = mem_rsp_data_i;
    c_mem_valid = mem_req_valid_o; c_mem_addr = mem_req_addr_o;
  end

  // behavioural reference: 0 idle, 1 dir req, 2 dir wait, 3 tbl req, 4 tbl wait, 5 result
  int          ph = 0;
  logic [31:0] m_va, m_base, m_ptb, m_phys;
  logic        m_fault;
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr;

  always @(negedge clk) begin
    cyc++;
    if (!rst_ni || !c_rst) begin
      ph = 0; pend = 0;
    end else begin
      if (c_mem_valid && c_mem_ready) begin
        reads++;
        pend = 1; pend_addr = c_mem_addr; pend_cnt = cyc % 4;
      end
      case (ph)
        0: if (c_req_valid) begin m_va = c_vaddr; m_base = c_base; ph = 1; end
        1: if (c_mem_ready) ph = 2;
        2: if (c_rsp_valid) begin
             if (!c_rsp_data[0]) begin m_fault = 1; m_phys = 0; ph = 5; end
             else begin m_ptb = c_rsp_data & 32'hFFFF_F000; ph = 3; end
           end
        3: if (c_mem_ready) ph = 4;
        4: if (c_rsp_valid) begin
             m_fault = !c_rsp_data[0];
             m_phys  = c_rsp_data[0] ? ((c_rsp_data & 32'hFFFF_F000) | (m_va & 32'hFFF)) : 0;
             ph = 5;
           end
        default: ph = 0;
      endcase
    end
    // compare every port against the model (R3 R4 R8 R9 R10 R11)
    chk("R9/R11 req_ready_o", {31'b0, req_ready_o}, {31'b0, ph == 0});
    chk("R10 mem_req_valid_o", {31'b0, mem_req_valid_o}, {31'b0, ph == 1 || ph == 3});
    if (ph == 1) chk("R3 dir entry addr", mem_req_addr_o, m_base + ((m_va >> 22) << 2));
    if (ph == 3) chk("R4 tbl entry addr", mem_req_addr_o, m_ptb + (((m_va >> 12) & 32'h3FF) << 2));
    chk("R8 done_o", {31'b0, done_o}, {31'b0, ph == 5});
    chk("R8 fault_o", {31'b0, fault_o}, {31'b0, ph == 5 && m_fault});
    chk("R8 phys_addr_o", phys_addr_o, (ph == 5) ? m_phys : 32'h0);
    // memory model: varied ready, latency and stray strobes
    mem_req_ready_i <= (cyc % 5 != 2);
    if (pend && pend_cnt == 0) begin
      mem_rsp_valid_i <= 1'b1; mem_rsp_data_i <= rd(pend_addr); pend = 0;
    end else if (!pend && (cyc % 3 == 1)) begin
      mem_rsp_valid_i <= 1'b1; mem_rsp_data_i <= 32'hFFFF_F001; // stray, R10
    end else begin
      mem_rsp_valid_i <= 1'b0; mem_rsp_data_i <= 32'hDEAD_BEE0;
      if (pend) pend_cnt--;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit exp_f,
                      input logic [31:0] exp_p, input int exp_reads, input bit hold, input string tag);
    int r0;
    bit got;
    do begin @(negedge clk); #1; end while (!req_ready_o);
    req_valid_i = 1; req_vaddr_i = va; req_base_i = base;
    @(posedge clk); #1;
    r0 = reads;
    if (!hold) begin
      req_valid_i = 0; req_vaddr_i = ~va; req_base_i = ~base; // R9: late changes ignored
    end
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk); #2;
      if (done_o) got = 1;
    end
    chk({tag, " done seen"}, {31'b0, got}, 32'd1);
    chk({tag, " fault"}, {31'b0, fault_o}, {31'b0, exp_f});
    chk({tag, " phys"}, phys_addr_o, exp_p);
    chk({tag, " reads"}, reads - r0, exp_reads);
  endtask

  localparam logic [31:0] D0 = 32'h0000_2000, D1 = 32'h0000_3000;
  localparam logic [31:0] P1 = 32'h1000_0000, P2 = 32'h8000_0000;

  initial begin
    mem[D0 + 0]      = 32'h1000_0555;
    mem[D0 + 8]      = 32'h8000_0555;
    mem[D0 + 4*1023] = 32'h8000_0001;
    mem[D1 + 4]      = 32'h1000_0FFF;
    mem[D0 + 12]     = 32'h7777_7FFE;     // frame set, not present
    mem[P1 + 0]      = 32'h0000_1AAB;
    mem[P1 + 8]      = 32'h0000_DAAB;
    mem[P1 + 4*1023] = 32'h0000_5001;
    mem[P2 + 0]      = 32'h0000_AFFF;
    mem[P2 + 4]      = 32'h0000_C555;
    mem[P2 + 8]      = 32'h1234_57FE;     // frame set, not present

    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset req_ready_o", {31'b0, req_ready_o}, 32'd1);
    chk("R1 reset mem_req_valid_o", {31'b0, mem_req_valid_o}, 32'd0);
    chk("R1 reset done_o", {31'b0, done_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk); #1;
    chk("R1 after release req_ready_o", {31'b0, req_ready_o}, 32'd1);

    walk(32'h0080_1004, D0, 0, 32'h0000_C004, 2, 0, "R2/R7 example");
    walk(32'h0000_0001, D0, 0, 32'h0000_1001, 2, 0, "R7 ignored bits");
    walk(32'h0000_1001, D0, 1, 32'h0, 2, 0, "R6 empty tbl entry");
    walk(32'h003F_F001, D0, 0, 32'h0000_5001, 2, 0, "R2 top tbl index");
    walk(32'h0040_0000, D0, 1, 32'h0, 1, 0, "R5 empty dir entry");
    walk(32'h00C0_0010, D0, 1, 32'h0, 1, 0, "R5 dir frame without present");
    walk(32'h0080_0001, D0, 0, 32'h0000_A001, 2, 0, "R4 second table");
    walk(32'h0080_2004, D0, 1, 32'h0, 2, 0, "R6 tbl frame without present");
    walk(32'h00B0_0001, D0, 1, 32'h0, 2, 0, "R6 unmapped tbl slot");
    walk(32'hFFC0_0123, D0, 0, 32'h0000_A123, 2, 0, "R2/R3 top dir index");
    walk(32'h0000_0FFF, D0, 0, 32'h0000_1FFF, 2, 0, "R7 max offset");
    walk(32'h0040_0ABC, D1, 0, 32'h0000_1ABC, 2, 0, "R3/R9 other base");
    walk(32'h0080_1004, D0, 0, 32'h0000_C004, 2, 1, "R11 held first");
    walk(32'h0080_1004, D0, 0, 32'h0000_C004, 2, 0, "R11 held second");
    repeat (20) @(negedge clk);
    #1;
    chk("R9 idle after walks", {31'b0, req_ready_o}, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule